// File: doc/BRIEF.md
# Reset time-out sequencer

This block decides when a processor core may leave reset or leave its stall after waking from sleep. It receives event strobes for power-on, brown-out and wake-up. It then times the delays the core needs before it runs, and drives a single registered release output. Two timers are used. One is a fixed power-up delay, counted in ticks of a slow reference clock. The other is an oscillator start-up wait, counted in cycles of the oscillator clock that also clocks the block.

The event type, the oscillator mode and the active-low timer enable together decide which timers run. Power events (power-on and brown-out) can use both timers. A wake-up never uses the power-up delay. When both timers are needed, the power-up delay runs first and the oscillator count follows. A crystal oscillator needs the start-up wait, while an RC oscillator needs none. The fixed delay is a parameter (`PWRT_TICKS` reference ticks, nominally 72 ms), so a testbench can shorten it. The oscillator wait is `OST_CYCLES` clock cycles, nominally 1024.

Top module: `rst_delay_seq`

## Requirements
- R1: After `rst_n` is deasserted, `core_go` is 0, and it stays 0 until a power event or a wake-up arrives.
- R2: A power event (`por_evt` or `bor_evt` high for one cycle) sampled while `pwrt_en_n` is 0 drops `core_go` on that edge. It then holds `core_go` at 0 until `PWRT_TICKS` `ref_tick` pulses have been sampled. The clock cycles that pass without a tick do not advance this delay.
- R3: In crystal mode (`xtal_mode` = 1), the oscillator wait starts on the edge that ends the power-up delay, or on the event edge when no power-up delay runs. `core_go` rises exactly `OST_CYCLES` clock edges later, and `ref_tick` has no effect on this count.
- R4: In RC mode (`xtal_mode` = 0) with the timer enabled, `core_go` rises on the edge that samples the final `ref_tick` of the power-up delay.
- R5: A power event in RC mode with `pwrt_en_n` = 1 sets `core_go` on the edge that samples the event.
- R6: A brown-out event produces exactly the same delays as a power-on event.
- R7: A wake-up (`wake_evt`) sampled while `core_go` is 1 never runs the power-up delay, whatever the value of `pwrt_en_n`. In crystal mode it drops `core_go` for `OST_CYCLES` edges. In RC mode `core_go` stays 1.
- R8: A wake-up is ignored while `core_go` is 0. When a power event and a wake-up are sampled together, the power event is acted on.
- R9: A power event during a running sequence restarts the sequence from its beginning.
- R10: The oscillator mode is captured on the event edge. Changes of `xtal_mode` during the sequence do not alter it.
- R11: `core_go` is a register output. Once it is 1, it stays 1 until an event arrives that needs a delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one cycle is one oscillator period |
| rst_n | input | 1 | Active-low asynchronous register reset |
| ref_tick | input | 1 | One-cycle strobe from the slow reference time base |
| pwrt_en_n | input | 1 | Power-up delay enable, 0 = enabled |
| xtal_mode | input | 1 | Oscillator mode, 1 = crystal, 0 = RC |
| por_evt | input | 1 | Power-on event strobe |
| bor_evt | input | 1 | Brown-out event strobe |
| wake_evt | input | 1 | Wake-from-sleep event strobe |
| core_go | output | 1 | Core release, 1 = core may run |

## Verification
The assertions assume that every event arrives as a strobe synchronous to `clk`. They also assume that `xtal_mode` and `pwrt_en_n` are valid on the edge that samples an event. Under these assumptions, the value of `core_go` on the next edge follows from those inputs alone. The bench drives every input at the falling edge, raises each strobe for exactly one cycle and spaces reference ticks a few cycles apart. It changes the mode only in the scenario that checks that the mode is captured at the event.

// File: rtl/rst_delay_seq.sv
module rst_delay_seq #(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic pwrt_en_n,
  input  logic xtal_mode,
  input  logic por_evt,
  input  logic bor_evt,
  input  logic wake_evt,
  output logic core_go
);
  localparam int LIM = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] PW_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OS_LAST = CW'(OST_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_PWRT, S_OST, S_RUN} st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic xtal_q, xtal_nx;

  wire pwr_evt = por_evt | bor_evt;
  wire wake_ok = wake_evt & (st == S_RUN);

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    xtal_nx = xtal_q;
    if (pwr_evt || wake_ok) begin
      xtal_nx = xtal_mode;
      cnt_nx  = '0;
      if (pwr_evt && !pwrt_en_n) st_nx = S_PWRT;
      else if (xtal_mode)        st_nx = S_OST;
      else                       st_nx = S_RUN;
    end else begin
      case (st)
        S_PWRT: if (ref_tick) begin
          if (cnt == PW_LAST) begin
            cnt_nx = '0;
            st_nx  = xtal_q ? S_OST : S_RUN;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        S_OST: begin
          if (cnt == OS_LAST) begin
            cnt_nx = '0;
            st_nx  = S_RUN;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      xtal_q  <= 1'b0;
      core_go <= 1'b0;
    end else begin
      st      <= st_nx;
      cnt     <= cnt_nx;
      xtal_q  <= xtal_nx;
      core_go <= (st_nx == S_RUN);
    end
  end
endmodule

// File: rtl/rst_delay_seq_chk.sv
module rst_delay_seq_chk #(
  parameter int CW  = 11,
  parameter int LIM = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwrt_en_n,
  input logic          xtal_mode,
  input logic          por_evt,
  input logic          bor_evt,
  input logic          wake_evt,
  input logic          core_go,
  input logic [CW-1:0] cnt
);
  assert_power_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((por_evt || bor_evt) && (xtal_mode || !pwrt_en_n)) |=> !core_go);

  assert_rc_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((por_evt || bor_evt) && !xtal_mode && pwrt_en_n) |=> core_go);

  assert_wake_xtal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && core_go && xtal_mode && !por_evt && !bor_evt) |=> !core_go);

  assert_release_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_go && !por_evt && !bor_evt && !(wake_evt && xtal_mode)) |=> core_go);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) < LIM));
endmodule

bind rst_delay_seq rst_delay_seq_chk #(.CW(CW), .LIM(LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrt_en_n(pwrt_en_n), .xtal_mode(xtal_mode),
  .por_evt(por_evt), .bor_evt(bor_evt), .wake_evt(wake_evt),
  .core_go(core_go), .cnt(cnt)
);

// File: tb/sim_rst_delay_seq.sv
module sim_rst_delay_seq;
  localparam int PW  = 6;
  localparam int OST = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, pwrt_en_n = 1'b0, xtal_mode = 1'b1;
  logic por_evt = 1'b0, bor_evt = 1'b0, wake_evt = 1'b0;
  logic core_go;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_delay_seq #(.PWRT_TICKS(PW), .OST_CYCLES(OST)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pwrt_en_n(pwrt_en_n),
    .xtal_mode(xtal_mode), .por_evt(por_evt), .bor_evt(bor_evt),
    .wake_evt(wake_evt), .core_go(core_go)
  );

  task automatic check(input string tag, input logic exp);
    total++;
    if (core_go !== exp) begin
      bad++;
      $display("FAIL %s core_go=%b expected %b at %0t", tag, core_go, exp, $time);
    end
  endtask

  task automatic strobe(input bit p, input bit b, input bit w);
    @(negedge clk);
    por_evt = p; bor_evt = b; wake_evt = w;
    @(negedge clk);
    por_evt = 1'b0; bor_evt = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (2) @(negedge clk);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  task automatic expect_ost(input string tag);
    repeat (OST - 1) @(negedge clk);
    check(tag, 1'b0);
    @(negedge clk);
    check(tag, 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", 1'b0);
    ticks(PW + 2);
    repeat (OST + 3) @(negedge clk);
    check("R1 no event", 1'b0);
  endtask

  task automatic t_power(input bit use_bor, input string tag);
    pwrt_en_n = 1'b0; xtal_mode = 1'b1;
    strobe(!use_bor, use_bor, 1'b0);
    check({tag, " R2 hold"}, 1'b0);
    ticks(PW - 1);
    repeat (OST + 5) @(negedge clk);
    check({tag, " R2 waits ticks"}, 1'b0);
    ticks(1);
    expect_ost({tag, " R3 ost after pwrt"});
  endtask

  task automatic t_rc_timer;
    pwrt_en_n = 1'b0; xtal_mode = 1'b0;
    strobe(1'b1, 1'b0, 1'b0);
    ticks(PW - 1);
    check("R4 before last tick", 1'b0);
    ticks(1);
    check("R4 release on last tick", 1'b1);
  endtask

  task automatic t_no_timer;
    pwrt_en_n = 1'b1; xtal_mode = 1'b1;
    strobe(1'b1, 1'b0, 1'b0);
    check("R3 xtal no timer hold", 1'b0);
    expect_ost("R3 xtal no timer");
    xtal_mode = 1'b0;
    strobe(1'b1, 1'b0, 1'b0);
    check("R5 rc no timer immediate", 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    check("R6 brown-out rc immediate", 1'b1);
  endtask

  task automatic t_wake;
    pwrt_en_n = 1'b0; xtal_mode = 1'b1;
    check("R11 running before wake", 1'b1);
    strobe(1'b0, 1'b0, 1'b1);
    check("R7 wake xtal hold", 1'b0);
    expect_ost("R7 wake xtal skips pwrt");
    xtal_mode = 1'b0;
    strobe(1'b0, 1'b0, 1'b1);
    check("R7 wake rc stays released", 1'b1);
    repeat (5) @(negedge clk);
    check("R11 sticky", 1'b1);
  endtask

  task automatic t_wake_ignored;
    pwrt_en_n = 1'b0; xtal_mode = 1'b1;
    strobe(1'b1, 1'b0, 1'b1);
    ticks(PW - 1);
    check("R8 power wins over wake", 1'b0);
    strobe(1'b0, 1'b0, 1'b1);
    check("R8 wake while held", 1'b0);
    ticks(1);
    expect_ost("R8 wake ignored");
  endtask

  task automatic t_restart;
    pwrt_en_n = 1'b0; xtal_mode = 1'b1;
    strobe(1'b1, 1'b0, 1'b0);
    ticks(3);
    strobe(1'b0, 1'b1, 1'b0);
    ticks(PW - 1);
    check("R9 restart in pwrt", 1'b0);
    ticks(1);
    repeat (OST / 2) @(negedge clk);
    strobe(1'b1, 1'b0, 1'b0);
    ticks(PW);
    expect_ost("R9 restart in ost");
  endtask

  task automatic t_latch;
    pwrt_en_n = 1'b0; xtal_mode = 1'b1;
    strobe(1'b1, 1'b0, 1'b0);
    xtal_mode = 1'b0;
    ticks(PW);
    check("R10 latched crystal", 1'b0);
    expect_ost("R10 latched crystal ost");
    xtal_mode = 1'b0;
    strobe(1'b1, 1'b0, 1'b0);
    xtal_mode = 1'b1;
    ticks(PW);
    check("R10 latched rc", 1'b1);
  endtask

  initial begin
    t_reset();
    t_power(1'b0, "por");
    t_power(1'b1, "R6 bor");
    t_rc_timer();
    t_no_timer();
    t_wake();
    t_wake_ignored();
    t_restart();
    t_latch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule